// File: doc/BRIEF.md
# Batched Transmit Queue Scheduler

This block keeps the books for Ethernet frames that a host has copied into a shared transmit buffer. Each frame is announced with one push that carries its byte length. The block does not start frames one at a time. When the transmitter is idle, a pushed frame goes out at once with a start command. While a transmission is in flight, later frames collect as a pending batch. When the transmitter reports completion, the whole batch is launched with a single start command that carries its frame count.

The block counts the pending frames and the buffer bytes they occupy. From that it drives a ready signal, which drops once the buffer can no longer be sure of holding one more maximum-size frame. A tick-driven watchdog clears all queue state and flags a transmit error if a launch is never followed by completion.

Serialization, CRC and collision handling lie outside the block. Completion arrives as a one-cycle done pulse.

Top module: `txq_batch_sched`

## Requirements
- R1: An accepted frame that goes pending adds max(length, 60) + 2 to the pending byte total (`pend_bytes`).
- R2: Every start command has bit 7 set and the launched frame count in bits 6:0, and it is presented on `start_cmd` while `start_valid` is high for one cycle.
- R3: A frame accepted while `busy` is low launches at once. The cycle after the accepting edge shows `start_valid` high, `start_cmd` = 0x81 and `busy` high, and the pending count and bytes stay 0.
- R4: A frame accepted while `busy` is high (after any done handling of that cycle) increments `pend_count` by one and issues no start.
- R5: `push_ready` is high exactly when three conditions all hold: `pend_bytes` is below the buffer size minus 1516, `pend_count` is below its cap, and the watchdog is not expiring in that cycle.
- R6: `buf_size_code` selects the buffer size: 0 and 1 give 2048 bytes, 2 gives 4096 bytes and 3 gives 8192 bytes.
- R7: A done pulse while `busy` is high and frames are pending launches them all with one start command carrying their count, and it clears `pend_count` and `pend_bytes`. `busy` stays high.
- R8: A done pulse while `busy` is high with nothing pending drops `busy`. A done pulse while `busy` is low has no effect.
- R9: When a push and a done pulse arrive in the same cycle, the done is handled first. The pushed frame then launches or goes pending according to the state left by the done.
- R10: Counting resets on every launch. Once busy, the 30th `wd_tick` since the last launch expires the watchdog. The following cycle shows `busy`, `pend_count` and `pend_bytes` all 0, `tx_err` high for one cycle and no start. Expiry overrides a done pulse in the same cycle, and the push in that cycle is refused.
- R11: `pend_count` saturates at 2^CNT_W - 1. At that value `push_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_size_code | input | 2 | Transmit buffer size select |
| push_valid | input | 1 | Host announces a frame written to the buffer |
| push_len | input | LEN_W | Frame length in bytes |
| push_ready | output | 1 | Frame can be accepted this cycle |
| tx_done | input | 1 | One-cycle transmit completion pulse |
| wd_tick | input | 1 | Watchdog time base pulse |
| start_valid | output | 1 | Start command strobe |
| start_cmd | output | 8 | Start command byte |
| busy | output | 1 | A batch is in flight |
| tx_err | output | 1 | Watchdog expiry pulse |
| pend_count | output | CNT_W | Frames waiting for the next launch |
| pend_bytes | output | BYTE_W | Buffer bytes used by pending frames |

## Verification
`push_ready` is combinational on the current state and on `wd_tick`, so the bench compares it in the same cycle, after driving the inputs and before the clock edge. Every other output is a register that changes at the first rising edge after the stimulus. The bench therefore checks the start strobe, command, `busy`, error pulse and pending counters just after that edge, against a model that is advanced once per cycle. Directed sequences cover the same-cycle done and push, the buffer limit for each size code, the count cap, and watchdog expiry at the exact 30th tick. Seeded random traffic covers the rest.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int MIN_FRAME_BYTES = 60;
    localparam int MAX_FRAME_BYTES = 1514;
    localparam int LEN_HDR_BYTES   = 2;
    localparam int MAX_SLOT_BYTES  = MAX_FRAME_BYTES + LEN_HDR_BYTES;

    function automatic int buf_bytes(input logic [1:0] code);
        case (code)
            2'd2:    return 4096;
            2'd3:    return 8192;
            default: return 2048;
        endcase
    endfunction
endpackage

// File: rtl/txq_frame_cost.sv
module txq_frame_cost #(
    parameter int LEN_W  = 11,
    parameter int BYTE_W = 14
) (
    input  logic [LEN_W-1:0]  len,
    output logic [BYTE_W-1:0] cost
);
    import txq_pkg::*;

    logic [BYTE_W-1:0] padded;

    always_comb begin
        if (int'(len) < MIN_FRAME_BYTES) padded = BYTE_W'(MIN_FRAME_BYTES);
        else                             padded = BYTE_W'(len);
        cost = padded + BYTE_W'(LEN_HDR_BYTES);
    end
endmodule

// File: rtl/txq_space_limit.sv
module txq_space_limit #(
    parameter int BYTE_W = 14
) (
    input  logic [1:0]        code,
    output logic [BYTE_W-1:0] limit
);
    import txq_pkg::*;

    always_comb begin
        limit = BYTE_W'(buf_bytes(code) - MAX_SLOT_BYTES);
    end
endmodule

// File: rtl/txq_watchdog.sv
module txq_watchdog #(
    parameter int TIMEOUT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic restart,
    output logic expire
);
    localparam int WD_W = $clog2(TIMEOUT + 1);

    logic [WD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q == WD_W'(TIMEOUT - 1));
        cnt_d  = cnt_q;
        if (restart)          cnt_d = '0;
        else if (run && tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/txq_batch_sched.sv
module txq_batch_sched #(
    parameter int LEN_W   = 11,
    parameter int CNT_W   = 7,
    parameter int BYTE_W  = 14,
    parameter int TIMEOUT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        buf_size_code,
    input  logic              push_valid,
    input  logic [LEN_W-1:0]  push_len,
    output logic              push_ready,
    input  logic              tx_done,
    input  logic              wd_tick,
    output logic              start_valid,
    output logic [7:0]        start_cmd,
    output logic              busy,
    output logic              tx_err,
    output logic [CNT_W-1:0]  pend_count,
    output logic [BYTE_W-1:0] pend_bytes
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              started;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] bytes;
        logic              sv;
        logic [7:0]        cmd;
        logic              err;
    } sched_t;

    sched_t            s_d, s_q;
    logic [BYTE_W-1:0] frame_cost;
    logic [BYTE_W-1:0] space_limit;
    logic              wd_expire;
    logic              launch;
    logic              wd_restart;
    logic              accept;

    txq_frame_cost #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_cost (
        .len  (push_len),
        .cost (frame_cost)
    );

    txq_space_limit #(.BYTE_W(BYTE_W)) u_limit (
        .code  (buf_size_code),
        .limit (space_limit)
    );

    txq_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.started),
        .tick    (wd_tick),
        .restart (wd_restart),
        .expire  (wd_expire)
    );

    always_comb begin
        push_ready = !wd_expire && (s_q.cnt != CNT_MAX) && (s_q.bytes < space_limit);
        accept     = push_valid && push_ready;
        s_d        = s_q;
        s_d.sv     = 1'b0;
        s_d.err    = 1'b0;
        launch     = 1'b0;
        if (wd_expire) begin
            s_d.started = 1'b0;
            s_d.cnt     = '0;
            s_d.bytes   = '0;
            s_d.err     = 1'b1;
        end else begin
            // completion is handled before a push of the same cycle
            if (tx_done && s_q.started) begin
                if (s_q.cnt != '0) begin
                    s_d.sv    = 1'b1;
                    s_d.cmd   = {1'b1, 7'(s_q.cnt)};
                    s_d.cnt   = '0;
                    s_d.bytes = '0;
                    launch    = 1'b1;
                end else begin
                    s_d.started = 1'b0;
                end
            end
            if (accept) begin
                if (!s_d.started) begin
                    s_d.started = 1'b1;
                    s_d.sv      = 1'b1;
                    s_d.cmd     = 8'h81;
                    launch      = 1'b1;
                end else begin
                    s_d.cnt   = s_d.cnt + 1'b1;
                    s_d.bytes = s_d.bytes + frame_cost;
                end
            end
        end
        wd_restart = launch || !s_d.started;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_valid = s_q.sv;
    assign start_cmd   = s_q.cmd;
    assign busy        = s_q.started;
    assign tx_err      = s_q.err;
    assign pend_count  = s_q.cnt;
    assign pend_bytes  = s_q.bytes;
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_ready,
    input logic             tx_done,
    input logic             busy,
    input logic             start_valid,
    input logic [7:0]       start_cmd,
    input logic             tx_err,
    input logic [CNT_W-1:0] pend_count,
    input logic             wd_expire
);
    // R2
    cmd_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> (start_cmd[7] && start_cmd[6:0] != 7'd0));

    // R3
    idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !busy) |=> (start_valid && start_cmd == 8'h81 && busy));

    // R7
    batch_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && busy && pend_count != '0 && !wd_expire)
        |=> (start_valid && start_cmd[6:0] == 7'($past(pend_count)) && busy));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && busy && pend_count == '0 && !wd_expire && !push_valid)
        |=> (!busy && !start_valid));

    // R10
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> (tx_err && !busy && pend_count == '0 && !start_valid));

    // R11
    cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == '1) |-> !push_ready);
endmodule

bind txq_batch_sched txq_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .push_ready  (push_ready),
    .tx_done     (tx_done),
    .busy        (busy),
    .start_valid (start_valid),
    .start_cmd   (start_cmd),
    .tx_err      (tx_err),
    .pend_count  (pend_count),
    .wd_expire   (wd_expire)
);

// File: tb/tb_txq_batch_sched.sv
`timescale 1ns/1ps
module tb_txq_batch_sched;
    localparam int LEN_W   = 11;
    localparam int CNT_W   = 3;
    localparam int BYTE_W  = 14;
    localparam int TIMEOUT = 30;
    localparam int CAP     = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        buf_size_code = 2'd0;
    logic              push_valid = 1'b0;
    logic [LEN_W-1:0]  push_len = '0;
    logic              push_ready;
    logic              tx_done = 1'b0;
    logic              wd_tick = 1'b0;
    logic              start_valid;
    logic [7:0]        start_cmd;
    logic              busy;
    logic              tx_err;
    logic [CNT_W-1:0]  pend_count;
    logic [BYTE_W-1:0] pend_bytes;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int m_started, m_cnt, m_bytes, m_wd;
    int e_sv, e_cmd, e_err;
    int acc_count;

    txq_batch_sched #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .TIMEOUT(TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .buf_size_code(buf_size_code),
        .push_valid(push_valid), .push_len(push_len), .push_ready(push_ready),
        .tx_done(tx_done), .wd_tick(wd_tick), .start_valid(start_valid),
        .start_cmd(start_cmd), .busy(busy), .tx_err(tx_err),
        .pend_count(pend_count), .pend_bytes(pend_bytes)
    );

    always #10 clk = ~clk;

    function automatic int f_cost(input int len);
        return ((len < 60) ? 60 : len) + 2;
    endfunction

    function automatic int f_limit(input int code);
        int sz;
        sz = (code == 2) ? 4096 : (code == 3) ? 8192 : 2048;
        return sz - 1516;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int code);
        @(negedge clk);
        rst_n = 1'b0; push_valid = 1'b0; tx_done = 1'b0; wd_tick = 1'b0;
        buf_size_code = 2'(code);
        m_started = 0; m_cnt = 0; m_bytes = 0; m_wd = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 reset busy", busy, 0);
        chk("R3 reset start", start_valid, 0);
        chk("R4 reset count", pend_count, 0);
        chk("R5 reset ready", push_ready, 1);
    endtask

    task automatic step(input bit pv, input int len, input bit dn, input bit tk);
        bit ex, rdy, acc, launch;
        @(negedge clk);
        push_valid = pv; push_len = LEN_W'(len); tx_done = dn; wd_tick = tk;
        #1;
        ex  = (m_started != 0) && tk && (m_wd == TIMEOUT - 1);
        rdy = !ex && (m_cnt < CAP) && (m_bytes < f_limit(buf_size_code));
        chk("R5 ready", push_ready, rdy);
        acc = pv && rdy;
        acc_count += acc;
        e_sv = 0; e_err = 0; launch = 0;
        if (ex) begin
            m_started = 0; m_cnt = 0; m_bytes = 0; e_err = 1;
        end else begin
            if (dn && m_started != 0) begin
                if (m_cnt > 0) begin
                    e_sv = 1; e_cmd = 128 + m_cnt; m_cnt = 0; m_bytes = 0; launch = 1;
                end else m_started = 0;
            end
            if (acc) begin
                if (m_started == 0) begin
                    m_started = 1; e_sv = 1; e_cmd = 129; launch = 1;
                end else begin
                    m_cnt++; m_bytes += f_cost(len);
                end
            end
        end
        if (launch || m_started == 0) m_wd = 0;
        else if (tk) m_wd++;
        @(posedge clk);
        #2;
        chk("R7 start_valid", start_valid, e_sv);
        if (e_sv != 0) chk("R2 start_cmd", start_cmd, e_cmd);
        chk("R8 busy", busy, m_started);
        chk("R10 tx_err", tx_err, e_err);
        chk("R4 pend_count", pend_count, m_cnt);
        chk("R1 pend_bytes", pend_bytes, m_bytes);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seed;
        int n;
        seed = 12345;
        void'($urandom(seed));

        // R3: idle push launches at once
        do_reset(0);
        step(1, 10, 0, 0);
        chk("R3 cmd", start_cmd, 8'h81);
        chk("R3 busy", busy, 1);
        // R1 / R4: padding and accumulation
        step(1, 10, 0, 0);
        chk("R1 padded", pend_bytes, 62);
        step(1, 100, 0, 0);
        chk("R1 sum", pend_bytes, 164);
        chk("R4 count", pend_count, 2);
        // R9: done and push together with two pending
        step(1, 70, 1, 0);
        chk("R9 batch cmd", start_cmd, 8'h82);
        chk("R9 new pending", pend_count, 1);
        step(0, 0, 1, 0);
        chk("R7 single", start_cmd, 8'h81);
        // R8 then R9: done with none pending plus push relaunches
        step(1, 80, 1, 0);
        chk("R9 relaunch", start_valid, 1);
        chk("R9 relaunch busy", busy, 1);
        step(0, 0, 1, 0);
        chk("R8 idle", busy, 0);
        step(0, 0, 1, 0);
        chk("R8 ignored", busy, 0);

        // R6 / R5: buffer limit per size code with maximum frames
        for (int code = 0; code < 4; code++) begin
            do_reset(code);
            step(1, 1514, 0, 0);
            n = 0;
            while (push_ready && n < 20) begin
                step(1, 1514, 0, 0);
                n++;
            end
            chk("R6 frames before full", n, (f_limit(code) + 1515) / 1516);
            step(1, 1514, 0, 0);
            chk("R5 refused", pend_count, n);
        end

        // R11: count cap with small frames in the large buffer
        do_reset(3);
        for (int i = 0; i < CAP + 3; i++) step(1, 20, 0, 0);
        chk("R11 cap", pend_count, CAP);
        chk("R11 ready", push_ready, 0);

        // R10: expiry at the 30th tick, overriding done and push
        do_reset(1);
        step(1, 64, 0, 0);
        step(1, 64, 0, 0);
        for (int i = 0; i < TIMEOUT - 1; i++) step(0, 0, 0, 1);
        chk("R10 not yet", tx_err, 0);
        step(1, 64, 1, 1);
        chk("R10 err", tx_err, 1);
        chk("R10 cleared", busy, 0);
        step(0, 0, 0, 0);
        chk("R10 pulse", tx_err, 0);

        // random traffic for each size code
        for (int code = 0; code < 4; code++) begin
            do_reset(code);
            for (int i = 0; i < 3000; i++)
                step(($urandom % 2) == 0, $urandom_range(0, 1514),
                     ($urandom % 10) == 0, ($urandom % 5) == 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule